// File: doc/BRIEF.md
# Wide-Function Lookup Cluster

This block holds four small lookup tables, each a 16-entry truth table addressed by its own four inputs. The tables sit in two pairs. In each pair, a dedicated 2:1 selector picks one of the two table results under an extra select input. A final 2:1 selector picks between the two pair results under one more select. Because of this tree, the cluster can realise any function of five inputs per pair, or any function of six inputs across the whole cluster. It can also act as a 4:1 multiplexer per pair or as an 8:1 multiplexer overall. None of these uses a second level of lookup tables.

Truth tables are loaded one at a time through a parallel configuration port. A table write takes effect at a rising clock edge. Reads need no clock: every output follows the inputs and the stored tables through combinational logic only. Each table result, each pair result and the final result are all brought out, so surrounding logic can use any level of the tree.

Top module: `lutx_cluster`

## Requirements
- R1: After an asynchronous reset (rst_n low), all four stored tables are zero, so every output is 0 whatever the data inputs are.
- R2: When cfg_we_i is high at a rising clock edge, the 16-bit cfg_tbl_i is stored into table k = cfg_idx_i. Tables 0 and 1 form pair 0 and tables 2 and 3 form pair 1; within a pair, the odd index is the upper table.
- R3: A write changes only the addressed table. When cfg_we_i is low, no table changes, whatever cfg_idx_i and cfg_tbl_i hold.
- R4: lut_o[k] equals bit n of table k, where n is the unsigned value of lut_in_i[4k+3:4k].
- R5: f5_o[p] equals lut_o[2p+1] when f5_sel_i[p] is 1 and lut_o[2p] when it is 0.
- R6: f6_o equals f5_o[1] when f6_sel_i is 1 and f5_o[0] when it is 0. Suppose all four input nibbles carry x, both f5_sel_i bits carry y and f6_sel_i carries z. Then f6_o is bit {z,y,x} of the 64-bit word {table3,table2,table1,table0}.
- R7: Load every table with the pattern whose bit n is (n[2] ? n[1] : n[0]). Drive table k with inputs {0, s[0], d[2k+1], d[2k]}, both pair selects with s[1], and the final select with s[2]. Then f6_o equals d[s] for any 8-bit d and 3-bit s.
- R8: Reads are combinational. A new input value shows on the outputs within the same cycle, and a newly written table is visible right after the writing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all tables |
| cfg_we_i | input | 1 | Table write enable |
| cfg_idx_i | input | 2 | Index of the table to write |
| cfg_tbl_i | input | 16 | Truth table to store |
| lut_in_i | input | 16 | Four 4-bit address nibbles, nibble k for table k |
| f5_sel_i | input | 2 | Pair selects, bit p picks the upper table of pair p |
| f6_sel_i | input | 1 | Final select, 1 picks pair 1 |
| lut_o | output | 4 | Result of each table |
| f5_o | output | 2 | Result of each pair selector |
| f6_o | output | 1 | Result of the final selector |

## Verification
The six-input test ties the tree together. Random 64-bit functions are loaded and all 64 input combinations are swept, so any mistake in table indexing, pair order or select polarity changes at least one bit. Random, independent nibbles and selects then exercise each table and each pair selector on its own, which separates faults that a tied-input sweep would mask. The 8:1 multiplexer pattern is checked over every data byte and select value. Directed writes with the enable low, writes to a single index, and an all-ones table show whether a write reaches the wrong table or appears too late.

// File: rtl/lutx_pkg.sv
package lutx_pkg;

    localparam int unsigned LUT_K_DEF = 4;
    localparam int unsigned PAIRS     = 2;
    localparam int unsigned PER_PAIR  = 2;
    localparam int unsigned NUM_LUTS  = PAIRS * PER_PAIR;

    typedef enum logic {
        PICK_LOWER = 1'b0,
        PICK_UPPER = 1'b1
    } pick_e;

    function automatic int unsigned lut_index(input int unsigned pair, input pick_e half);
        return pair * PER_PAIR + int'(half);
    endfunction

endpackage

// File: rtl/lutx_table.sv
module lutx_table #(
    parameter  int unsigned K     = 4,
    localparam int unsigned TBL_W = 1 << K
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [TBL_W-1:0] wr_tbl_i,
    input  logic [K-1:0]     addr_i,
    output logic             out_o
);

    typedef struct packed {
        logic [TBL_W-1:0] tbl;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.tbl = wr_tbl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.tbl[addr_i];

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.tbl == '0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.tbl == $past(wr_tbl_i))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.tbl)); // R3

endmodule

// File: rtl/lutx_pair.sv
module lutx_pair #(
    parameter  int unsigned K     = 4,
    localparam int unsigned TBL_W = 1 << K,
    localparam int unsigned N     = lutx_pkg::PER_PAIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     wr_en_i,
    input  logic [TBL_W-1:0] wr_tbl_i,
    input  logic [N*K-1:0]   lut_in_i,
    input  logic             f5_sel_i,
    output logic [N-1:0]     lut_o,
    output logic             f5_o
);

    for (genvar h = 0; h < N; h++) begin : g_tbl
        lutx_table #(.K(K)) tbl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_en_i[h]),
            .wr_tbl_i (wr_tbl_i),
            .addr_i   (lut_in_i[h*K +: K]),
            .out_o    (lut_o[h])
        );
    end

    always_comb begin
        if (lutx_pkg::pick_e'(f5_sel_i) == lutx_pkg::PICK_UPPER) begin
            f5_o = lut_o[1];
        end else begin
            f5_o = lut_o[0];
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_i)); // R3

    AST_F5_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lut_o) && $stable(f5_sel_i)) |-> $stable(f5_o)); // R5

endmodule

// File: rtl/lutx_cluster.sv
module lutx_cluster #(
    parameter  int unsigned K     = lutx_pkg::LUT_K_DEF,
    localparam int unsigned TBL_W = 1 << K,
    localparam int unsigned NL    = lutx_pkg::NUM_LUTS,
    localparam int unsigned NP    = lutx_pkg::PAIRS,
    localparam int unsigned PP    = lutx_pkg::PER_PAIR,
    localparam int unsigned IDX_W = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [TBL_W-1:0] cfg_tbl_i,
    input  logic [NL*K-1:0]  lut_in_i,
    input  logic [NP-1:0]    f5_sel_i,
    input  logic             f6_sel_i,
    output logic [NL-1:0]    lut_o,
    output logic [NP-1:0]    f5_o,
    output logic             f6_o
);

    logic [NL-1:0] wr_vec;

    always_comb begin
        wr_vec = '0;
        if (cfg_we_i) begin
            wr_vec[cfg_idx_i] = 1'b1;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_pair
        lutx_pair #(.K(K)) pair_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_vec[p*PP +: PP]),
            .wr_tbl_i (cfg_tbl_i),
            .lut_in_i (lut_in_i[p*PP*K +: PP*K]),
            .f5_sel_i (f5_sel_i[p]),
            .lut_o    (lut_o[p*PP +: PP]),
            .f5_o     (f5_o[p])
        );
    end

    always_comb begin
        if (lutx_pkg::pick_e'(f6_sel_i) == lutx_pkg::PICK_UPPER) begin
            f6_o = f5_o[1];
        end else begin
            f6_o = f5_o[0];
        end
    end

    AST_F6_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        f6_o == lut_o[{f6_sel_i, f5_sel_i[f6_sel_i]}]); // R6

    AST_RESET_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lut_o == '0 && f5_o == '0 && !f6_o)); // R1

endmodule

// File: tb/lutx_cluster_tb.sv
`timescale 1ns/1ps
module lutx_cluster_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_idx_i = '0;
    logic [15:0] cfg_tbl_i = '0;
    logic [15:0] lut_in_i = '0;
    logic [1:0]  f5_sel_i = '0;
    logic        f6_sel_i = 1'b0;
    logic [3:0]  lut_o;
    logic [1:0]  f5_o;
    logic        f6_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model [4];

    always #2.5 clk = ~clk;

    lutx_cluster dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
        .cfg_tbl_i(cfg_tbl_i), .lut_in_i(lut_in_i), .f5_sel_i(f5_sel_i),
        .f6_sel_i(f6_sel_i), .lut_o(lut_o), .f5_o(f5_o), .f6_o(f6_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_f5(input int p);
        logic [3:0] n = lut_in_i[(2*p+f5_sel_i[p])*4 +: 4];
        return model[2*p+f5_sel_i[p]][n];
    endfunction

    task automatic write_tbl(input int k, input logic [15:0] t);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_idx_i = 2'(k); cfg_tbl_i = t;
        @(negedge clk);
        cfg_we_i = 1'b0;
        model[k] = t;
    endtask

    task automatic sweep_tables(input string req);
        for (int n = 0; n < 16; n++) begin
            lut_in_i = {4{4'(n)}};
            #1;
            for (int k = 0; k < 4; k++) begin
                chk(8'(lut_o[k]), 8'(model[k][n]), req, $sformatf("table %0d entry %0d", k, n));
            end
        end
    endtask

    task automatic check_all_outs(input string req);
        logic [3:0] n;
        #1;
        for (int k = 0; k < 4; k++) begin
            n = lut_in_i[k*4 +: 4];
            chk(8'(lut_o[k]), 8'(model[k][n]), "R4", $sformatf("%s lut %0d", req, k));
        end
        for (int p = 0; p < 2; p++) chk(8'(f5_o[p]), 8'(exp_f5(p)), "R5", $sformatf("%s pair %0d", req, p));
        chk(8'(f6_o), 8'(exp_f5(int'(f6_sel_i))), "R6", req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] big;
        logic [15:0] m8;
        logic [7:0]  d;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1357);
        for (int k = 0; k < 4; k++) model[k] = '0;

        // R1: outputs zero under reset and just after release
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            lut_in_i = 16'($urandom); f5_sel_i = 2'($urandom); f6_sel_i = 1'($urandom);
            #1;
            chk(8'({lut_o, f5_o, f6_o}), 8'h00, "R1", "outputs in reset");
        end
        rst_n = 1'b1;
        @(negedge clk);
        sweep_tables("R1");

        // R7-style directed: R2 write to the upper table of pair 1, R3 others unchanged
        write_tbl(3, 16'hFFFF);
        sweep_tables("R2");
        write_tbl(0, 16'h8001);
        sweep_tables("R3");

        // R3: enable low with live index and data
        @(negedge clk);
        cfg_idx_i = 2'd1; cfg_tbl_i = 16'hBEEF;
        repeat (2) @(negedge clk);
        sweep_tables("R3");

        // R8: new table visible right after the writing edge
        @(negedge clk);
        lut_in_i = {4{4'd5}};
        cfg_we_i = 1'b1; cfg_idx_i = 2'd2; cfg_tbl_i = 16'h0020;
        @(posedge clk); #1;
        cfg_we_i = 1'b0; model[2] = 16'h0020;
        chk(8'(lut_o[2]), 8'h01, "R8", "table visible after edge");
        lut_in_i = {4{4'd4}}; #1;
        chk(8'(lut_o[2]), 8'h00, "R8", "input change same cycle");

        // R6: random 64-bit functions, all 64 combinations
        for (int r = 0; r < 4; r++) begin
            big = {32'($urandom), 32'($urandom)};
            for (int k = 0; k < 4; k++) write_tbl(k, big[k*16 +: 16]);
            for (int v = 0; v < 64; v++) begin
                lut_in_i = {4{4'(v)}}; f5_sel_i = {2{v[4]}}; f6_sel_i = v[5];
                #1;
                chk(8'(f6_o), 8'(big[v]), "R6", $sformatf("func %0d combo %0d", r, v));
            end
        end

        // R4 R5 R6: independent nibbles and selects
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            lut_in_i = 16'($urandom); f5_sel_i = 2'($urandom); f6_sel_i = 1'($urandom);
            check_all_outs("random mix");
        end

        // R7: 8:1 multiplexer
        for (int n = 0; n < 16; n++) m8[n] = n[2] ? n[1] : n[0];
        for (int k = 0; k < 4; k++) write_tbl(k, m8);
        for (int di = 0; di < 256; di++) begin
            d = 8'(di);
            for (int s = 0; s < 8; s++) begin
                for (int k = 0; k < 4; k++) lut_in_i[k*4 +: 4] = {1'b0, 1'(s), d[2*k+1], d[2*k]};
                f5_sel_i = {2{s[1]}}; f6_sel_i = s[2];
                #1;
                chk(8'(f6_o), 8'(d[s]), "R7", $sformatf("data %h sel %0d", d, s));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule